// File: doc/BRIEF.md
# Bus Address Decoder with Traps

This block sits between a processor's bus request and the rest of a minicomputer-style system bus. Each cycle it may receive one read or write request carrying a byte address. It sorts that request into exactly one of three outcomes: a main-memory access (with the memory word index), a selection of one I/O device register window (one-hot), or a bus-error trap. The split between memory and the I/O page depends on an address-width mode: a narrow mode limits memory to a small installed size and puts the I/O page just under the 18-bit ceiling. A wide mode allows a larger memory and moves the I/O page to the top of the 22-bit space. Addresses in the I/O page are cut to 18 bits before decoding, so the device windows sit at the same place in both modes.

The block also holds four memory-management status words that sit in the I/O page. Two are plain read/write words. One is a read-only snapshot driven from outside. The fourth keeps only three bits, and one of them is the mode bit that moves the memory/I-O boundary. All outputs are registered and appear in the cycle after the request. Device models, memory arrays and the trap handler live elsewhere.

Top module: `bus_addr_decode`

## Requirements
- R1: A request with address bit 0 set raises `bus_trap` one cycle later, with `rd_data` = 0, no memory enable and no device select.
- R2: Bit 4 (value 'o020) of status word 3 picks wide mode. While it is clear, the narrow memory size `MEM18_BYTES` and I/O base `IO18_BASE` apply. While it is set, `MEM22_BYTES` and `IO22_BASE` apply.
- R3: An even address below the memory size of the current mode gives `mem_en` = 1 one cycle later, with `mem_idx` = address >> 1 and `mem_we` = 1 exactly for writes.
- R4: An even address at or above the memory size but below the I/O base of the current mode raises `bus_trap`.
- R5: An address at or above the I/O base is cut to its low 18 bits and matched in 64-byte windows. `dev_sel` bit 0 is window 'o777400, bit 1 is 'o774400, bit 6 is windows 'o770200 and 'o770300, and bit 7 is windows 'o772200, 'o772300 and 'o777600. `dev_addr` carries the 18-bit address.
- R6: Shared windows are decoded by exact address. `dev_sel` bit 2 covers 'o775610 through 'o775617 and 'o776500 through 'o776507; the rest of those two windows traps. In window 'o777500, bit 3 covers 'o777514 and 'o777516 and bit 4 covers 'o777546. The status words are at 'o777572, 'o777574 and 'o777576. Bit 5 covers every other address in that window.
- R7: Status words 0 ('o777572) and 1 ('o777574) read back what was last written. A read of word 2 ('o777576) returns `snap_in` as it is in the request cycle. A write to word 2 does nothing and does not trap. Internal reads set `rd_valid` with the value on `rd_data` one cycle later.
- R8: Status word 3 ('o772516) keeps only bits 5:3 of a write (mask 'o070); the other addresses of window 'o772500 trap. Reset clears status words 0 and 3, which returns the block to narrow mode.
- R9: An I/O-page address that matches no window above raises `bus_trap`.
- R10: `bus_trap` is high only in the cycle after a trapping request. When it is high, `mem_en`, `dev_sel` and `rd_valid` are all 0. A cycle without a request leaves every strobe low in the next cycle.
- R11: `dev_sel` has at most one bit set.
- R12: A request with both `req_rd` and `req_wr` high is handled as a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| snap_in | input | DATA_W | Value returned by status word 2 |
| mem_en | output | 1 | Main-memory access this cycle |
| mem_we | output | 1 | Main-memory access is a write |
| mem_idx | output | ADDR_W-1 | Memory word index |
| wr_data | output | DATA_W | Registered write data for memory or device |
| dev_sel | output | NDEV | One-hot device window select |
| dev_we | output | 1 | Device access is a write |
| dev_addr | output | 18 | Reduced I/O address for the selected device |
| rd_valid | output | 1 | `rd_data` holds an internal status-word read |
| rd_data | output | DATA_W | Read data of status words, 0 otherwise |
| bus_trap | output | 1 | One-cycle bus-error pulse |

## Verification
A write to status word 3 changes the boundary between memory and the I/O page at the same clock edge where the request is registered. The request in the very next cycle is therefore classified under the new mode. The bench provokes this by placing status-word-3 writes with random data directly before requests to addresses whose outcome depends on the mode, such as 'o777400: that address is memory in wide mode and a disk window in narrow mode. Each result is judged against a bench model that applies the write before it classifies the following request.

// File: rtl/bad_pkg.sv
package bad_pkg;

  localparam int unsigned IO_W      = 18;
  localparam int unsigned NDEV      = 8;
  localparam int unsigned WIN_LSB   = 6;
  localparam int unsigned SUB_LSB   = 3;
  localparam int unsigned WIDE_BIT  = 4;

  localparam int unsigned DEV_DISK_A  = 0;
  localparam int unsigned DEV_DISK_B  = 1;
  localparam int unsigned DEV_SERIAL  = 2;
  localparam int unsigned DEV_PRINT   = 3;
  localparam int unsigned DEV_CLOCK   = 4;
  localparam int unsigned DEV_CONSOLE = 5;
  localparam int unsigned DEV_MAP     = 6;
  localparam int unsigned DEV_PAGE    = 7;

  typedef enum logic [1:0] {RG_MEM, RG_HOLE, RG_IO, RG_ODD} region_e;
  typedef enum logic [2:0] {IR_NONE, IR_S0, IR_S1, IR_S2, IR_S3} ireg_e;

  localparam logic [IO_W-1:0] WIN_DISK_A = 18'o777400;
  localparam logic [IO_W-1:0] WIN_DISK_B = 18'o774400;
  localparam logic [IO_W-1:0] WIN_SER_A  = 18'o775600;
  localparam logic [IO_W-1:0] SUB_SER_A  = 18'o775610;
  localparam logic [IO_W-1:0] WIN_SER_B  = 18'o776500;
  localparam logic [IO_W-1:0] SUB_SER_B  = 18'o776500;
  localparam logic [IO_W-1:0] WIN_SYS    = 18'o777500;
  localparam logic [IO_W-1:0] ADR_PRN_0  = 18'o777514;
  localparam logic [IO_W-1:0] ADR_PRN_1  = 18'o777516;
  localparam logic [IO_W-1:0] ADR_CLK    = 18'o777546;
  localparam logic [IO_W-1:0] ADR_S0     = 18'o777572;
  localparam logic [IO_W-1:0] ADR_S1     = 18'o777574;
  localparam logic [IO_W-1:0] ADR_S2     = 18'o777576;
  localparam logic [IO_W-1:0] WIN_S3     = 18'o772500;
  localparam logic [IO_W-1:0] ADR_S3     = 18'o772516;
  localparam logic [IO_W-1:0] WIN_MAP_0  = 18'o770200;
  localparam logic [IO_W-1:0] WIN_MAP_1  = 18'o770300;
  localparam logic [IO_W-1:0] WIN_PAGE_0 = 18'o772200;
  localparam logic [IO_W-1:0] WIN_PAGE_1 = 18'o772300;
  localparam logic [IO_W-1:0] WIN_PAGE_2 = 18'o777600;

endpackage

// File: rtl/bad_region.sv
module bad_region
  import bad_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 22,
  parameter logic [ADDR_W-1:0] MEM18_BYTES = 22'o200000,
  parameter logic [ADDR_W-1:0] IO18_BASE   = 22'o760000,
  parameter logic [ADDR_W-1:0] MEM22_BYTES = 22'o4000000,
  parameter logic [ADDR_W-1:0] IO22_BASE   = 22'o17760000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide_mode,
  output region_e           region
);

  logic [ADDR_W-1:0] mem_limit;
  logic [ADDR_W-1:0] io_floor;

  // Both limit pairs are constants; the mode only steers a mux.
  assign mem_limit = wide_mode ? MEM22_BYTES : MEM18_BYTES;
  assign io_floor  = wide_mode ? IO22_BASE   : IO18_BASE;

  always_comb begin
    if (addr[0])                region = RG_ODD;
    else if (addr < mem_limit)  region = RG_MEM;
    else if (addr < io_floor)   region = RG_HOLE;
    else                        region = RG_IO;
  end

endmodule

// File: rtl/bad_io_match.sv
module bad_io_match
  import bad_pkg::*;
(
  input  logic [IO_W-1:0] io_addr,
  output logic [NDEV-1:0] dev_hot,
  output ireg_e           ireg,
  output logic            miss
);

  logic [IO_W-WIN_LSB-1:0] win;
  logic [IO_W-SUB_LSB-1:0] sub;

  assign win = io_addr[IO_W-1:WIN_LSB];
  assign sub = io_addr[IO_W-1:SUB_LSB];

  always_comb begin
    dev_hot = '0;
    ireg    = IR_NONE;
    case (win)
      WIN_DISK_A[IO_W-1:WIN_LSB]: dev_hot[DEV_DISK_A] = 1'b1;
      WIN_DISK_B[IO_W-1:WIN_LSB]: dev_hot[DEV_DISK_B] = 1'b1;
      WIN_SER_A[IO_W-1:WIN_LSB]:
        if (sub == SUB_SER_A[IO_W-1:SUB_LSB]) dev_hot[DEV_SERIAL] = 1'b1;
      WIN_SER_B[IO_W-1:WIN_LSB]:
        if (sub == SUB_SER_B[IO_W-1:SUB_LSB]) dev_hot[DEV_SERIAL] = 1'b1;
      WIN_SYS[IO_W-1:WIN_LSB]: begin
        if (io_addr == ADR_PRN_0 || io_addr == ADR_PRN_1)
          dev_hot[DEV_PRINT] = 1'b1;
        else if (io_addr == ADR_CLK)
          dev_hot[DEV_CLOCK] = 1'b1;
        else if (io_addr == ADR_S0)
          ireg = IR_S0;
        else if (io_addr == ADR_S1)
          ireg = IR_S1;
        else if (io_addr == ADR_S2)
          ireg = IR_S2;
        else
          dev_hot[DEV_CONSOLE] = 1'b1;
      end
      WIN_S3[IO_W-1:WIN_LSB]:
        if (io_addr == ADR_S3) ireg = IR_S3;
      WIN_MAP_0[IO_W-1:WIN_LSB],
      WIN_MAP_1[IO_W-1:WIN_LSB]:  dev_hot[DEV_MAP] = 1'b1;
      WIN_PAGE_0[IO_W-1:WIN_LSB],
      WIN_PAGE_1[IO_W-1:WIN_LSB],
      WIN_PAGE_2[IO_W-1:WIN_LSB]: dev_hot[DEV_PAGE] = 1'b1;
      default: ;
    endcase
  end

  assign miss = (dev_hot == '0) && (ireg == IR_NONE);

endmodule

// File: rtl/bad_stat_regs.sv
module bad_stat_regs
  import bad_pkg::*;
#(
  parameter int unsigned       DATA_W    = 16,
  parameter logic [DATA_W-1:0] KEEP_MASK = 16'o000070
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  ireg_e             sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] snap_in,
  output logic [DATA_W-1:0] rdata,
  output logic              wide_mode
);

  logic [DATA_W-1:0] stat0;
  logic [DATA_W-1:0] stat1;
  logic [DATA_W-1:0] stat3;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat0 <= '0;
      stat3 <= '0;
    end else if (wr_en) begin
      case (sel)
        IR_S0:   stat0 <= wdata;
        IR_S1:   stat1 <= wdata;
        IR_S3:   stat3 <= wdata & KEEP_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      IR_S0:   rdata = stat0;
      IR_S1:   rdata = stat1;
      IR_S2:   rdata = snap_in;
      IR_S3:   rdata = stat3;
      default: rdata = '0;
    endcase
  end

  assign wide_mode = stat3[WIDE_BIT];

endmodule

// File: rtl/bus_addr_decode.sv
module bus_addr_decode
  import bad_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 22,
  parameter int unsigned       DATA_W      = 16,
  parameter logic [ADDR_W-1:0] MEM18_BYTES = 22'o200000,
  parameter logic [ADDR_W-1:0] IO18_BASE   = 22'o760000,
  parameter logic [ADDR_W-1:0] MEM22_BYTES = 22'o4000000,
  parameter logic [ADDR_W-1:0] IO22_BASE   = 22'o17760000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] snap_in,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-2:0] mem_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [NDEV-1:0]   dev_sel,
  output logic              dev_we,
  output logic [IO_W-1:0]   dev_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_trap
);

  localparam logic [DATA_W-1:0] STAT3_KEEP = DATA_W'(16'o000070);

  logic              req_any;
  logic              wide_mode;
  region_e           region;
  logic [NDEV-1:0]   dev_hot;
  ireg_e             ireg;
  logic              io_miss;
  logic [DATA_W-1:0] stat_rdata;
  logic              hit_mem;
  logic              hit_io;
  logic              hit_int;
  logic              take_trap;

  // Both strobes together count as a write (R12).
  assign req_any = req_rd | req_wr;

  bad_region #(
    .ADDR_W      (ADDR_W),
    .MEM18_BYTES (MEM18_BYTES),
    .IO18_BASE   (IO18_BASE),
    .MEM22_BYTES (MEM22_BYTES),
    .IO22_BASE   (IO22_BASE)
  ) u_region (
    .addr      (req_addr),
    .wide_mode (wide_mode),
    .region    (region)
  );

  bad_io_match u_match (
    .io_addr (req_addr[IO_W-1:0]),
    .dev_hot (dev_hot),
    .ireg    (ireg),
    .miss    (io_miss)
  );

  assign hit_mem   = req_any && (region == RG_MEM);
  assign hit_io    = req_any && (region == RG_IO) && !io_miss;
  assign hit_int   = hit_io && (ireg != IR_NONE);
  assign take_trap = req_any && !hit_mem && !hit_io;

  bad_stat_regs #(
    .DATA_W    (DATA_W),
    .KEEP_MASK (STAT3_KEEP)
  ) u_stat (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (hit_int && req_wr),
    .sel       (ireg),
    .wdata     (req_wdata),
    .snap_in   (snap_in),
    .rdata     (stat_rdata),
    .wide_mode (wide_mode)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en   <= 1'b0;
      mem_we   <= 1'b0;
      mem_idx  <= '0;
      wr_data  <= '0;
      dev_sel  <= '0;
      dev_we   <= 1'b0;
      dev_addr <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bus_trap <= 1'b0;
    end else begin
      mem_en   <= hit_mem;
      mem_we   <= hit_mem && req_wr;
      mem_idx  <= req_addr[ADDR_W-1:1];
      wr_data  <= req_wdata;
      dev_sel  <= hit_io ? dev_hot : '0;
      dev_we   <= hit_io && !hit_int && req_wr;
      dev_addr <= req_addr[IO_W-1:0];
      rd_valid <= hit_int && !req_wr;
      rd_data  <= (hit_int && !req_wr) ? stat_rdata : '0;
      bus_trap <= take_trap;
    end
  end

endmodule

// File: rtl/bad_checker.sv
module bad_checker #(
  parameter int unsigned ADDR_W = 22,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NDEV   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_rd,
  input logic              req_wr,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_en,
  input logic              mem_we,
  input logic [NDEV-1:0]   dev_sel,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              bus_trap,
  input logic              wide_mode
);

  assert_odd_trap_R1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past((req_rd || req_wr) && req_addr[0]))
      |-> (bus_trap && rd_data == '0));

  assert_mem_even_R3: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> !$past(req_addr[0]));

  assert_reset_narrow_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wide_mode);

  assert_trap_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    bus_trap |-> (!mem_en && dev_sel == '0 && !rd_valid));

  assert_needs_req_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_trap || mem_en || rd_valid || dev_sel != '0) |-> $past(req_rd || req_wr));

  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_sel));

  assert_both_write_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_en && $past(req_wr)) |-> mem_we);

endmodule

bind bus_addr_decode bad_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NDEV   (bad_pkg::NDEV)
) u_bad_checker (
  .clk       (clk),
  .rst       (rst),
  .req_rd    (req_rd),
  .req_wr    (req_wr),
  .req_addr  (req_addr),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .dev_sel   (dev_sel),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .bus_trap  (bus_trap),
  .wide_mode (wide_mode)
);

// File: tb/test_bus_addr_decode.sv
module test_bus_addr_decode;

  localparam int unsigned AW = 22;
  localparam int unsigned DW = 16;
  localparam logic [AW-1:0] M18 = 22'o200000;
  localparam logic [AW-1:0] B18 = 22'o760000;
  localparam logic [AW-1:0] M22 = 22'o4000000;
  localparam logic [AW-1:0] B22 = 22'o17760000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_rd = 1'b0, req_wr = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, snap_in = '0;
  logic          mem_en, mem_we, dev_we, rd_valid, bus_trap;
  logic [AW-2:0] mem_idx;
  logic [DW-1:0] wr_data, rd_data;
  logic [7:0]    dev_sel;
  logic [17:0]   dev_addr;

  int n_chk = 0;
  int n_err = 0;

  // Bench copy of the status words, kept from the requirements.
  logic [DW-1:0] m_s0 = '0, m_s1 = '0, m_s3 = '0;
  logic [17:0] xl [30];

  always #10 clk = ~clk;

  bus_addr_decode #(
    .ADDR_W(AW), .DATA_W(DW),
    .MEM18_BYTES(M18), .IO18_BASE(B18), .MEM22_BYTES(M22), .IO22_BASE(B22)
  ) i_bus_addr_decode (
    .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .snap_in(snap_in),
    .mem_en(mem_en), .mem_we(mem_we), .mem_idx(mem_idx), .wr_data(wr_data),
    .dev_sel(dev_sel), .dev_we(dev_we), .dev_addr(dev_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .bus_trap(bus_trap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Outcome model. ir: 0 none, 1..4 status words 0..3.
  function automatic void model(input logic rd, input logic wr, input logic [AW-1:0] a,
                                output logic e_trap, output logic e_mem,
                                output logic [7:0] e_dev, output int ir, output string why);
    logic [AW-1:0] lim, base;
    logic [17:0] r;
    logic wide;
    wide = m_s3[4];
    lim  = wide ? M22 : M18;
    base = wide ? B22 : B18;
    e_trap = 1'b0; e_mem = 1'b0; e_dev = '0; ir = 0; why = "R10 idle";
    if (!(rd || wr)) return;
    r = a[17:0];
    if (a[0]) begin e_trap = 1'b1; why = "R1 odd"; return; end
    if (a < lim) begin e_mem = 1'b1; why = "R3 memory"; return; end
    if (a < base) begin e_trap = 1'b1; why = "R4 hole"; return; end
    why = "R5 window";
    case ({r[17:6], 6'b0})
      18'o777400: e_dev[0] = 1'b1;
      18'o774400: e_dev[1] = 1'b1;
      18'o775600: begin why = "R6 serial"; if ({r[17:3], 3'b0} == 18'o775610) e_dev[2] = 1'b1; end
      18'o776500: begin why = "R6 serial"; if ({r[17:3], 3'b0} == 18'o776500) e_dev[2] = 1'b1; end
      18'o777500: begin
        why = "R6 shared";
        if (r == 18'o777514 || r == 18'o777516) e_dev[3] = 1'b1;
        else if (r == 18'o777546) e_dev[4] = 1'b1;
        else if (r == 18'o777572) begin ir = 1; why = "R7 status0"; end
        else if (r == 18'o777574) begin ir = 2; why = "R7 status1"; end
        else if (r == 18'o777576) begin ir = 3; why = "R7 status2"; end
        else e_dev[5] = 1'b1;
      end
      18'o772500: begin why = "R8 status3"; if (r == 18'o772516) ir = 4; end
      18'o770200, 18'o770300: e_dev[6] = 1'b1;
      18'o772200, 18'o772300, 18'o777600: e_dev[7] = 1'b1;
      default: ;
    endcase
    if (e_dev == '0 && ir == 0) begin e_trap = 1'b1; why = "R9 miss"; end
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input string note);
    logic e_trap, e_mem;
    logic [7:0] e_dev;
    int ir;
    string why;
    logic [DW-1:0] e_rd, snap;
    logic e_rv;
    snap = DW'($urandom);
    model(rd, wr, a, e_trap, e_mem, e_dev, ir, why);
    e_rv = (ir != 0) && !wr;
    case (ir)
      1: e_rd = m_s0;
      2: e_rd = m_s1;
      3: e_rd = snap;
      4: e_rd = m_s3;
      default: e_rd = '0;
    endcase
    if (!e_rv) e_rd = '0;
    req_rd = rd; req_wr = wr; req_addr = a; req_wdata = d; snap_in = snap;
    @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
    chk({note, " ", why, " trap"}, 32'(bus_trap), 32'(e_trap));
    chk({note, " ", why, " mem_en"}, 32'(mem_en), 32'(e_mem));
    chk({note, " ", why, " dev_sel R11"}, 32'(dev_sel), 32'(e_dev));
    chk({note, " ", why, " rd_data"}, 32'(rd_data), 32'(e_rd));
    chk({note, " ", why, " rd_valid"}, 32'(rd_valid), 32'(e_rv));
    if (e_mem) begin
      chk({note, " R3 mem_idx"}, 32'(mem_idx), 32'(a[AW-1:1]));
      chk({note, " R3 R12 mem_we"}, 32'(mem_we), 32'(wr));
    end
    if (e_dev != '0) chk({note, " R5 dev_addr"}, 32'(dev_addr), 32'(a[17:0]));
    if (wr) begin
      if (ir == 1) m_s0 = d;
      if (ir == 2) m_s1 = d;
      if (ir == 4) m_s3 = d & 16'o000070;
    end
  endtask

  function automatic logic [AW-1:0] io_hi();
    return m_s3[4] ? 22'o17000000 : 22'o0;
  endfunction

  function automatic logic [AW-1:0] pick(input int k);
    logic [AW-1:0] lim, base;
    lim  = m_s3[4] ? M22 : M18;
    base = m_s3[4] ? B22 : B18;
    case (k)
      0: return AW'(($urandom % (lim / 2)) * 2);
      1: return lim + AW'(($urandom % ((base - lim) / 2)) * 2);
      2: return base + AW'(($urandom % 4096) * 2);
      3: return io_hi() | AW'(xl[$urandom % 30]);
      4: return AW'($urandom) | 22'd1;
      default: return AW'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    xl = '{18'o777400, 18'o777476, 18'o774400, 18'o774476, 18'o775610, 18'o775616,
           18'o775600, 18'o775620, 18'o776500, 18'o776506, 18'o776510, 18'o777514,
           18'o777516, 18'o777546, 18'o777572, 18'o777574, 18'o777576, 18'o777500,
           18'o777570, 18'o772516, 18'o772514, 18'o770200, 18'o770376, 18'o772200,
           18'o772376, 18'o777600, 18'o777676, 18'o760000, 18'o777000, 18'o772600};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // Reset state (R8, R10)
    chk("R10 reset strobes", {28'd0, mem_en, bus_trap, rd_valid, |dev_sel}, 32'd0);
    step(1, 0, 22'o777572, 0, "R8 reset");
    step(1, 0, 22'o772516, 0, "R8 reset");
    step(0, 1, 22'o777574, 16'h5a5a, "R7");
    step(1, 0, 22'o777574, 0, "R7");
    step(0, 1, 22'o777576, 16'hffff, "R7 ro");
    step(1, 0, 22'o777576, 0, "R7 ro");
    step(0, 1, 22'o777572, 16'h1234, "R7");
    step(1, 0, 22'o777572, 0, "R7");
    step(1, 1, 22'o777572, 16'hbeef, "R12");
    step(1, 0, 22'o777572, 0, "R12");
    step(1, 1, 22'o000100, 16'h0001, "R12");
    // Narrow-mode boundaries (R2)
    step(1, 0, M18 - 2, 0, "R2");
    step(1, 0, M18, 0, "R2");
    step(1, 0, B18 - 2, 0, "R2");
    step(1, 0, 22'o777400, 0, "R2");
    step(1, 0, 22'o777401, 0, "R1");
    step(0, 0, 0, 0, "R10");
    step(0, 1, 22'o772516, 16'hffff, "R8 mask");
    step(1, 0, 22'o772516, 0, "R8 mask");
    // Wide mode: same address now memory
    step(1, 0, 22'o777400, 0, "R2");
    step(1, 0, M22 - 2, 0, "R2");
    step(1, 0, M22, 0, "R2");
    step(1, 0, B22 - 2, 0, "R2");
    step(1, 0, 22'o17777400, 0, "R2");
    step(1, 0, 22'o17772600, 0, "R9");
    step(0, 0, 0, 0, "R10");
    // Mid-run reset returns to narrow mode
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    m_s0 = '0; m_s3 = '0;
    step(1, 0, 22'o777400, 0, "R8 rerst");
    step(1, 0, 22'o777572, 0, "R8 rerst");
    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic w, r;
      k = int'($urandom % 9);
      w = $urandom % 2;
      r = !w || ($urandom % 4 == 0);
      if (k == 6) step(0, 1, io_hi() | 22'o772516, DW'($urandom), "R2 flip");
      else if (k == 7) step(r, w, io_hi() | ((($urandom % 2) == 0) ? 22'o777572 : 22'o777574),
                            DW'($urandom), "R7 rnd");
      else if (k == 8) step(0, 0, AW'($urandom), 0, "R10 rnd");
      else step(r, w, pick(k), DW'($urandom), "rnd");
    end
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule